// File: doc/BRIEF.md
# Correlator Result Readout Port

This block parks one complex correlation result so that a host processor can read it over an asynchronous, memory-mapped 16-bit bus. When the datapath strobes a new result, the block splits the 32-bit real part and the 32-bit imaginary part into four 16-bit holding registers. It then raises a ready flag that tells the host a fresh value is waiting.

The host reaches the registers by asserting its chip enable and placing a two-bit register index on the low address lines. The block drives the shared data bus only while chip enable is active, and leaves it released otherwise. The read strobe and chip enable cross into the block's clock through two-flop synchronisers. The block counts completed reads, and the ready flag drops once all four halves have been fetched. If a new result lands before the host has fetched all four halves, the old value is replaced, the count starts again and a sticky overrun flag records the loss.

Top module: `corr_readout_port`

## Requirements
- R1: A high `res_valid` at a clock edge loads `res_re` and `res_im` into the holding registers, and `data_ready` is high from that edge on.
- R2: Index `host_addr` selects the halves this way: 0 returns real bits 31:16, 1 returns real bits 15:0, 2 returns imaginary bits 31:16, 3 returns imaginary bits 15:0.
- R3: `host_data` is driven only while `host_cs` is high. While `host_cs` is low the bus is released, and another driver's value is seen unchanged.
- R4: A read counts when `host_rd` falls while `host_cs` is high. Both inputs pass through two synchronising flops. After the fourth counted read, `data_ready` is low by the third clock edge after the strobe's fall and stays low until the next capture.
- R5: After fewer than four counted reads, `data_ready` stays high. A strobe pulse with `host_cs` low is not counted.
- R6: A capture while `data_ready` is high overwrites the registers, restarts the count from zero and sets `overrun`. `overrun` stays set until reset.
- R7: Strobes counted while `data_ready` is low have no effect: after the next capture, four more reads are still needed to clear `data_ready`.
- R8: The synchronous active-high `rst` clears the holding registers to zero, the read count, `data_ready` and `overrun`.
- R9: When a capture and a counted read fall in the same cycle, the capture wins and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Single-cycle strobe marking a new result |
| res_re | input | 32 | Real part of the result |
| res_im | input | 32 | Imaginary part of the result |
| host_cs | input | 1 | Host chip enable, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_addr | input | 2 | Half-word index |
| host_data | inout | 16 | Shared host data bus, driven only while selected |
| data_ready | output | 1 | A result is waiting to be read |
| overrun | output | 1 | Sticky flag: a result was replaced before it was fully read |

## Verification
The bench builds the block with its default 32-bit result parts, four 16-bit halves and two synchroniser stages. With these values the half-word map and the four-read release of the ready flag can be observed directly at the pins. The bench walks through full, partial, out-of-order and unselected read sequences. It also covers a result that arrives mid-sequence, and a capture timed to land in the same cycle as a counted read.

// File: rtl/corr_rd_pkg.sv
package corr_rd_pkg;
  typedef enum logic [1:0] {
    SEL_RE_HI = 2'd0,
    SEL_RE_LO = 2'd1,
    SEL_IM_HI = 2'd2,
    SEL_IM_LO = 2'd3
  } half_sel_e;
endpackage

// File: rtl/corr_sync.sv
module corr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/corr_hold_bank.sv
module corr_hold_bank #(
  parameter int PART_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PART_W-1:0] re,
  input  logic [PART_W-1:0] im,
  input  logic [1:0]        sel,
  output logic [HALF_W-1:0] rdata
);
  import corr_rd_pkg::*;
  localparam int NUM_HALVES = 2 * PART_W / HALF_W;

  logic [HALF_W-1:0] halves [NUM_HALVES];
  logic [HALF_W-1:0] src    [NUM_HALVES];

  assign src[SEL_RE_HI] = re[PART_W-1 -: HALF_W];
  assign src[SEL_RE_LO] = re[HALF_W-1:0];
  assign src[SEL_IM_HI] = im[PART_W-1 -: HALF_W];
  assign src[SEL_IM_LO] = im[HALF_W-1:0];

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)       halves[g] <= '0;
      else if (load) halves[g] <= src[g];
    end
  end

  assign rdata = halves[sel];
endmodule

// File: rtl/corr_read_tracker.sv
module corr_read_tracker #(
  parameter int NUM_READS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic rd_sync,
  input  logic cs_sync,
  output logic ready,
  output logic overrun
);
  localparam int CNT_W = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_READS - 1);

  logic             rd_d, cs_d;
  logic [CNT_W-1:0] cnt;
  logic             rd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d <= 1'b0;
      cs_d <= 1'b0;
    end else begin
      rd_d <= rd_sync;
      cs_d <= cs_sync;
    end
  end

  // strobe fall, qualified by chip enable seen alongside the high strobe
  assign rd_done = rd_d & ~rd_sync & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else if (capture) begin
      cnt     <= '0;
      ready   <= 1'b1;
      overrun <= overrun | ready;
    end else if (rd_done && ready) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        ready <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/corr_readout_port.sv
module corr_readout_port #(
  parameter int PART_W      = 32,
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [PART_W-1:0] res_re,
  input  logic [PART_W-1:0] res_im,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  inout  wire  [HALF_W-1:0] host_data,
  output logic              data_ready,
  output logic              overrun
);
  localparam int NUM_HALVES = 2 * PART_W / HALF_W;

  logic [1:0]        strobes_s;
  logic [HALF_W-1:0] rdata;

  corr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_cs, host_rd}),
    .q   (strobes_s)
  );

  corr_hold_bank #(.PART_W(PART_W), .HALF_W(HALF_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .load  (res_valid),
    .re    (res_re),
    .im    (res_im),
    .sel   (host_addr),
    .rdata (rdata)
  );

  corr_read_tracker #(.NUM_READS(NUM_HALVES)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .capture (res_valid),
    .rd_sync (strobes_s[0]),
    .cs_sync (strobes_s[1]),
    .ready   (data_ready),
    .overrun (overrun)
  );

  assign host_data = host_cs ? rdata : {HALF_W{1'bz}};
endmodule

// File: rtl/corr_readout_port_chk.sv
module corr_readout_port_chk (
  input logic clk,
  input logic rst,
  input logic res_valid,
  input logic data_ready,
  input logic overrun
);
  // R1
  capture_ready_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> data_ready);
  // R1
  ready_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(res_valid));
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && data_ready) |=> overrun);
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!data_ready && !res_valid) |=> !data_ready);
  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(res_valid && data_ready));
endmodule

bind corr_readout_port corr_readout_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .res_valid  (res_valid),
  .data_ready (data_ready),
  .overrun    (overrun)
);

// File: tb/corr_readout_port_tb_top.sv
module corr_readout_port_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        res_valid;
  logic [31:0] res_re, res_im;
  logic        host_cs, host_rd;
  logic [1:0]  host_addr;
  wire  [15:0] host_data;
  logic        data_ready, overrun;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [15:0] exp_q [$];
  logic [15:0] got_word;
  string       got_tag;
  event        got_ev;

  always #2 clk = ~clk;

  // other bus agent: drives a marker whenever the block is not selected
  assign host_data = host_cs ? 16'hzzzz : 16'hA5A5;

  corr_readout_port dut_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_re(res_re), .res_im(res_im),
    .host_cs(host_cs), .host_rd(host_rd), .host_addr(host_addr),
    .host_data(host_data), .data_ready(data_ready), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as each read word comes back
  initial begin
    forever begin
      @(got_ev);
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL %s actual=%h expected=<none>", got_tag, got_word);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (got_word !== e) begin
          n_errors++;
          $display("FAIL %s actual=%h expected=%h", got_tag, got_word, e);
        end
      end
    end
  end

  task automatic push_result(input logic [31:0] re, input logic [31:0] im);
    @(negedge clk);
    res_re = re; res_im = im; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // driver: pushes the expected word, performs one bus read
  task automatic host_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    @(negedge clk);
    host_addr = a; host_cs = 1'b1;
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    got_word = host_data; got_tag = tag;
    -> got_ev;
    host_rd = 1'b0;
    @(negedge clk);
    host_cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_all(input logic [31:0] re, input logic [31:0] im, input string tag);
    host_read(2'd0, re[31:16], tag);
    host_read(2'd1, re[15:0],  tag);
    host_read(2'd2, im[31:16], tag);
    host_read(2'd3, im[15:0],  tag);
  endtask

  initial begin
    rst = 1'b1; res_valid = 1'b0; res_re = '0; res_im = '0;
    host_cs = 1'b0; host_rd = 1'b0; host_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state, registers read as zero
    check("R8 ready after reset", data_ready, 0);
    check("R8 overrun after reset", overrun, 0);
    host_cs = 1'b1;
    for (int a = 0; a < 4; a++) begin
      host_addr = 2'(a);
      #1 check("R8 zero register", host_data, 0);
    end
    host_cs = 1'b0;
    @(negedge clk);
    // R3: released bus shows the other agent's value
    check("R3 bus released", host_data, 16'hA5A5);

    // R1, R2, R4: full read in order
    push_result(32'h1234_5678, 32'h9ABC_DEF0);
    check("R1 ready after capture", data_ready, 1);
    read_all(32'h1234_5678, 32'h9ABC_DEF0, "R2 map");
    check("R4 ready low after four reads", data_ready, 0);
    check("R6 no overrun", overrun, 0);

    // R7: reads while not ready do not count
    host_read(2'd1, 16'h5678, "R7 read while idle");
    host_read(2'd2, 16'h9ABC, "R7 read while idle");
    push_result(32'hCAFE_0001, 32'h0BAD_F00D);
    host_read(2'd3, 16'hF00D, "R2 out of order");
    host_read(2'd0, 16'hCAFE, "R2 out of order");
    host_read(2'd2, 16'h0BAD, "R2 out of order");
    check("R5 ready after three reads", data_ready, 1);
    // R5: unselected strobe not counted
    @(negedge clk); host_rd = 1'b1;
    repeat (3) @(negedge clk); host_rd = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 unselected strobe ignored", data_ready, 1);
    check("R3 bus released while idle", host_data, 16'hA5A5);
    host_read(2'd1, 16'h0001, "R7 fourth read");
    check("R7 ready low after four", data_ready, 0);

    // R6: overwrite mid-sequence
    push_result(32'h1111_2222, 32'h3333_4444);
    host_read(2'd0, 16'h1111, "R6 first result");
    host_read(2'd1, 16'h2222, "R6 first result");
    push_result(32'h5555_6666, 32'h7777_8888);
    check("R6 overrun set", overrun, 1);
    host_read(2'd0, 16'h5555, "R6 new data");
    host_read(2'd1, 16'h6666, "R6 new data");
    host_read(2'd2, 16'h7777, "R6 new data");
    check("R6 count restarted", data_ready, 1);
    host_read(2'd3, 16'h8888, "R6 new data");
    check("R6 ready low", data_ready, 0);
    check("R6 overrun sticky", overrun, 1);

    // R9: capture lands in the cycle the third read is counted
    push_result(32'hAAAA_BBBB, 32'hCCCC_DDDD);
    host_read(2'd0, 16'hAAAA, "R9 pre");
    host_read(2'd1, 16'hBBBB, "R9 pre");
    @(negedge clk); host_addr = 2'd2; host_cs = 1'b1;
    @(negedge clk); host_rd = 1'b1;
    repeat (2) @(negedge clk); host_rd = 1'b0;
    // fall sampled at next edge, visible two edges later, counted on third
    @(negedge clk);
    @(negedge clk);
    res_re = 32'hDEAD_BEEF; res_im = 32'h0123_4567; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0; host_cs = 1'b0;
    repeat (4) @(negedge clk);
    host_read(2'd0, 16'hDEAD, "R9 capture wins");
    host_read(2'd1, 16'hBEEF, "R9 capture wins");
    host_read(2'd2, 16'h0123, "R9 capture wins");
    check("R9 count from zero", data_ready, 1);
    host_read(2'd3, 16'h4567, "R9 capture wins");
    check("R9 ready low", data_ready, 0);

    // R8: reset clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 overrun cleared", overrun, 0);
    host_read(2'd3, 16'h0000, "R8 registers cleared");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    #1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule